// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is an SPI master that a host drives through a small 32-bit register bus. The host picks one of four chip selects, sets the serial clock divider and the clock polarity and phase, then writes a byte to the transmit register. That write starts a full-duplex exchange of one byte, most significant bit first. When the exchange ends, the received byte is held in the receive register. A done flag is raised both in the control register and in an interrupt status register, and the interrupt status can drive a single maskable interrupt line.

Reads return data combinationally while the read enable is high. Writes take effect on the clock edge at which the write enable is sampled. Two self-clearing configuration bits are provided. One clears the receive register and reports this as a ready event. The other aborts the engine and clears the flags, and it leaves the chip selects as they are.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads zero, all four chip selects are low, SCLK is low and the interrupt output is low.
- R2: Bits 19:16 of the control register (offset 0x00) drive the chip selects, with bit 16+n driving cs[n]. They read back as written, and writing them to zero drops every select.
- R3: Each SCLK half-period lasts max(N,1) clock cycles, where N is configuration bits 4:0 (offset 0x04). One byte takes exactly 16 SCLK edges.
- R4: SCLK idles at configuration bit 7 (polarity). With configuration bit 6 (phase) clear, MOSI is valid before the first edge, MISO is sampled on each leading edge and MOSI changes on trailing edges. With phase set, MOSI changes on leading edges and MISO is sampled on trailing edges. Bytes move MSB first.
- R5: A write to offset 0x08 starts an exchange of bits 7:0. At completion, offset 0x0C bits 7:0 hold the received byte and control bit 0 (done) reads 1. Done reads 0 again once the next exchange starts.
- R6: A write to offset 0x08 during an exchange is ignored, and the running exchange completes unchanged.
- R7: Interrupt status (offset 0x28) bit 0 is set on completion and bit 1 is set when a flush completes. Writing a one clears a bit, and writing a zero leaves it unchanged.
- R8: The interrupt output is high exactly when some status bit is set whose mask bit (offset 0x2C, bits 1:0) is also set.
- R9: Configuration bit 9 (flush) clears the receive register, sets status bit 1 and clears itself one cycle after it is written, so a later read returns 0.
- R10: Writing configuration bit 16 (soft reset) aborts any exchange, returns SCLK to its idle level and clears the done flag and the status bits. The chip selects are kept, and the bit always reads 0.
- R11: Configuration bits 5, 10 to 13 and 17 read as zero and have no effect; every exchange uses one data line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rdata is zero while low |
| rdata | output | 32 | Read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs | output | 4 | Active-high chip selects |
| irq | output | 1 | Masked interrupt |

## Verification
The bench uses the default parameters: an 8-bit byte, four selects and a 5-bit divider. This lets it sweep the divider over its whole range, including the zero value, the value one and the largest value 31, and it measures the SCLK half-period in every case. A bench device model checks all four polarity and phase combinations in both directions. With a divider of 8 or more the exchange lasts long enough for the bench to collide a second transmit write or a soft reset with it mid-byte.

// File: rtl/spibm_pkg.sv
package spibm_pkg;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h04;
  localparam logic [7:0] OFF_TXD   = 8'h08;
  localparam logic [7:0] OFF_RXD   = 8'h0C;
  localparam logic [7:0] OFF_ISTAT = 8'h28;
  localparam logic [7:0] OFF_IMASK = 8'h2C;

  localparam int unsigned CTRL_CS_LSB = 16;
  localparam int unsigned CFG_CPHA    = 6;
  localparam int unsigned CFG_CPOL    = 7;
  localparam int unsigned CFG_FLUSH   = 9;
  localparam int unsigned CFG_SRST    = 16;

  localparam int unsigned STAT_W      = 2;
  localparam int unsigned STAT_DONE   = 0;
  localparam int unsigned STAT_READY  = 1;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

endpackage

// File: rtl/spibm_divider.sv
module spibm_divider #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == limit) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the half-period counter never passes the latched limit
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/spibm_shifter.sv
module spibm_shifter
  import spibm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PSC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [PSC_W-1:0]  psc,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi
);

  localparam int unsigned EDGES = 2 * BYTE_W;
  localparam int unsigned EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  eng_state_e        state_q, state_d;
  logic [PSC_W-1:0]  lim_q, lim_d;
  logic              cpha_q, cpha_d, cpol_q, cpol_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic              tog_q, tog_d;
  logic [BYTE_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              mosi_q, mosi_d;
  logic              done_q, done_d;
  logic              tick, leading, sample;

  spibm_divider #(.CNT_W(PSC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ENG_RUN),
    .limit (lim_q),
    .tick  (tick)
  );

  assign leading = ~edge_q[0];
  assign sample  = leading ^ cpha_q;

  always_comb begin
    state_d = state_q;
    lim_d   = lim_q;
    cpha_d  = cpha_q;
    cpol_d  = cpol_q;
    edge_d  = edge_q;
    tog_d   = tog_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    mosi_d  = mosi_q;
    done_d  = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        tog_d = 1'b0;
        if (start) begin
          state_d = ENG_RUN;
          lim_d   = (psc == '0) ? '0 : psc - 1'b1;
          cpha_d  = cpha;
          cpol_d  = cpol;
          edge_d  = '0;
          rx_d    = '0;
          if (cpha) begin
            tx_d   = tx_byte;
            mosi_d = 1'b0;
          end else begin
            mosi_d = tx_byte[BYTE_W-1];
            tx_d   = tx_byte << 1;
          end
        end
      end
      ENG_RUN: begin
        if (tick) begin
          tog_d  = ~tog_q;
          edge_d = edge_q + 1'b1;
          if (sample) begin
            rx_d = {rx_q[BYTE_W-2:0], miso};
          end else if (edge_q != LAST_EDGE) begin
            mosi_d = tx_q[BYTE_W-1];
            tx_d   = tx_q << 1;
          end
          if (edge_q == LAST_EDGE) begin
            state_d = ENG_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    if (abort) begin
      state_d = ENG_IDLE;
      tog_d   = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      lim_q   <= '0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      edge_q  <= '0;
      tog_q   <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lim_q   <= lim_d;
      cpha_q  <= cpha_d;
      cpol_q  <= cpol_d;
      edge_q  <= edge_d;
      tog_q   <= tog_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      mosi_q  <= mosi_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q == ENG_RUN);
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign mosi    = mosi_q;
  assign sclk    = tog_q ^ (busy ? cpol_q : cpol);

  // R4: an idle engine has returned SCLK to its resting phase
  assert_idle_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tog_q);

  // R5: completion is only reported right after a running exchange
  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(state_q == ENG_RUN));

  // R3: a byte never counts past its last edge
  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (edge_q < EW'(EDGES)));

  // R6: a running exchange continues unless it reaches its end or is aborted
  assert_run_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && !(tick && edge_q == LAST_EDGE)) |=> busy);

endmodule

// File: rtl/spibm_regs.sv
module spibm_regs
  import spibm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PSC_W  = 5,
  parameter int unsigned CS_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic              soft_rst,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [PSC_W-1:0]  psc,
  output logic              cpol,
  output logic              cpha,
  output logic [CS_N-1:0]   cs,
  output logic              irq
);

  logic [CS_N-1:0]   cs_q, cs_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic              cpol_q, cpol_d, cpha_q, cpha_d;
  logic              flush_q, flush_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic [STAT_W-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic [STAT_W-1:0] mask_q, mask_d;
  logic wr_ctrl, wr_cfg, wr_txd, wr_stat, wr_mask;

  assign wr_ctrl = wr_en && (addr == OFF_CTRL[ADDR_W-1:0]);
  assign wr_cfg  = wr_en && (addr == OFF_CFG[ADDR_W-1:0]);
  assign wr_txd  = wr_en && (addr == OFF_TXD[ADDR_W-1:0]);
  assign wr_stat = wr_en && (addr == OFF_ISTAT[ADDR_W-1:0]);
  assign wr_mask = wr_en && (addr == OFF_IMASK[ADDR_W-1:0]);

  assign start    = wr_txd && !busy;
  assign soft_rst = wr_cfg && wdata[CFG_SRST];
  assign tx_byte  = wdata[BYTE_W-1:0];

  always_comb begin
    cs_d    = wr_ctrl ? wdata[CTRL_CS_LSB +: CS_N] : cs_q;
    psc_d   = wr_cfg ? wdata[PSC_W-1:0] : psc_q;
    cpol_d  = wr_cfg ? wdata[CFG_CPOL] : cpol_q;
    cpha_d  = wr_cfg ? wdata[CFG_CPHA] : cpha_q;
    flush_d = wr_cfg && wdata[CFG_FLUSH];

    done_d = done_q;
    if (start)    done_d = 1'b0;
    if (done)     done_d = 1'b1;
    if (soft_rst) done_d = 1'b0;

    rxd_d = rxd_q;
    if (done)    rxd_d = rx_byte;
    if (flush_q) rxd_d = '0;

    stat_set = '0;
    stat_set[STAT_DONE]  = done;
    stat_set[STAT_READY] = flush_q;
    stat_clr = wr_stat ? wdata[STAT_W-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
    if (soft_rst) stat_d = '0;

    mask_d = wr_mask ? wdata[STAT_W-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      psc_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
      rxd_q   <= '0;
      stat_q  <= '0;
      mask_q  <= '0;
    end else begin
      cs_q    <= cs_d;
      psc_q   <= psc_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      flush_q <= flush_d;
      done_q  <= done_d;
      rxd_q   <= rxd_d;
      stat_q  <= stat_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFF_CTRL[ADDR_W-1:0]) begin
        rdata[CTRL_CS_LSB +: CS_N] = cs_q;
        rdata[0] = done_q;
      end else if (addr == OFF_CFG[ADDR_W-1:0]) begin
        rdata[PSC_W-1:0]  = psc_q;
        rdata[CFG_CPHA]   = cpha_q;
        rdata[CFG_CPOL]   = cpol_q;
        rdata[CFG_FLUSH]  = flush_q;
      end else if (addr == OFF_RXD[ADDR_W-1:0]) begin
        rdata[BYTE_W-1:0] = rxd_q;
      end else if (addr == OFF_ISTAT[ADDR_W-1:0]) begin
        rdata[STAT_W-1:0] = stat_q;
      end else if (addr == OFF_IMASK[ADDR_W-1:0]) begin
        rdata[STAT_W-1:0] = mask_q;
      end
    end
  end

  assign psc  = psc_q;
  assign cpol = cpol_q;
  assign cpha = cpha_q;
  assign cs   = cs_q;
  assign irq  = |(stat_q & mask_q);

  // R7: a one written to the done status bit clears it when no new event arrives
  assert_w1c_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[STAT_DONE] && !done) |=> !stat_q[STAT_DONE]);

  // R9: the flush bit lasts a single cycle unless written again
  assert_flush_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !(wr_cfg && wdata[CFG_FLUSH])) |=> !flush_q);

  // R5: launching an exchange drops the done flag
  assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q);

  // R10: soft reset keeps the chip selects
  assert_srst_keeps_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_ctrl) |=> $stable(cs_q));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PSC_W  = 5,
  parameter int unsigned CS_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs,
  output logic              irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              busy, done, start, soft_rst, cpol, cpha;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [PSC_W-1:0]  psc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  spibm_regs #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .PSC_W  (PSC_W),
    .CS_N   (CS_N)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .busy     (busy),
    .done     (done),
    .rx_byte  (rx_byte),
    .start    (start),
    .soft_rst (soft_rst),
    .tx_byte  (tx_byte),
    .psc      (psc),
    .cpol     (cpol),
    .cpha     (cpha),
    .cs       (cs),
    .irq      (irq)
  );

  spibm_shifter #(
    .BYTE_W (BYTE_W),
    .PSC_W  (PSC_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .abort   (soft_rst),
    .cpol    (cpol),
    .cpha    (cpha),
    .psc     (psc),
    .tx_byte (tx_byte),
    .miso    (miso),
    .busy    (busy),
    .done    (done),
    .rx_byte (rx_byte),
    .sclk    (sclk),
    .mosi    (mosi)
  );

endmodule

// File: tb/spi_byte_master_tb_top.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;

  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_TXD = 8'h08,
                         A_RXD = 8'h0C, A_STAT = 8'h28, A_MASK = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en, rd_en, miso;
  logic [31:0] wdata, rdata;
  logic        sclk, mosi, irq;
  logic [3:0]  cs;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_byte_master dut_i (
    .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .wdata (wdata),
    .rd_en (rd_en), .rdata (rdata), .sclk (sclk), .mosi (mosi), .miso (miso),
    .cs (cs), .irq (irq)
  );

  // bench device model
  logic       s_en = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0;
  logic [7:0] s_tx, s_rx;
  int         s_edges, s_bad, s_half;
  longint     s_last;

  always @(sclk) begin
    if (s_en) begin
      if (s_edges > 0 && ($time - s_last) != longint'(s_half * 4)) s_bad++;
      s_last = $time;
      s_edges++;
      if ((sclk != s_cpol) ^ s_cpha) s_rx = {s_rx[6:0], mosi};
      else begin
        miso = s_tx[7];
        s_tx = {s_tx[6:0], 1'b0};
      end
    end
  end

  function automatic int exp_half(int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [31:0] cfg_word(logic pol, logic pha, logic [4:0] p);
    return {24'd0, pol, pha, 1'b0, p};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CTRL, v);
      if (v[0]) return;
    end
  endtask

  task automatic arm(logic pol, logic pha, logic [4:0] p, logic [7:0] sb);
    s_cpol = pol; s_cpha = pha; s_half = exp_half(int'(p));
    s_rx = 8'h00; s_edges = 0; s_bad = 0;
    if (!pha) begin miso = sb[7]; s_tx = {sb[6:0], 1'b0}; end
    else s_tx = sb;
    s_en = 1'b1;
  endtask

  task automatic xfer(logic pol, logic pha, logic [4:0] p, int csn,
                      logic [7:0] tb, logic [7:0] sb, bit inject);
    logic [31:0] v;
    wr(A_CFG, cfg_word(pol, pha, p));
    wr(A_CTRL, 32'h1 << (16 + csn));
    chk("R4 idle sclk level", {31'd0, sclk}, {31'd0, pol});
    chk("R2 chip select", {28'd0, cs}, {28'd0, 4'b0001 << csn});
    arm(pol, pha, p, sb);
    wr(A_TXD, {24'd0, tb});
    if (inject) begin
      repeat (3) @(negedge clk);
      wr(A_TXD, {24'd0, ~tb});
    end
    wait_done();
    s_en = 1'b0;
    rd(A_RXD, v);
    chk("R5 received byte", v, {24'd0, sb});
    chk("R4 device captured MOSI", {24'd0, s_rx}, {24'd0, tb});
    chk("R3 edge count", s_edges, 16);
    chk("R3 half-period mismatches", s_bad, 0);
    rd(A_STAT, v);
    chk("R7 done status", {31'd0, v[0]}, 32'd1);
    chk("R4 sclk back at idle", {31'd0, sclk}, {31'd0, pol});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; miso = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    foreach (A_LIST[i]) begin end
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
    rd(A_CFG, v);  chk("R1 cfg reset", v, 0);
    rd(A_RXD, v);  chk("R1 rxd reset", v, 0);
    rd(A_STAT, v); chk("R1 stat reset", v, 0);
    rd(A_MASK, v); chk("R1 mask reset", v, 0);
    chk("R1 outputs reset", {28'd0, cs, sclk, irq, mosi}, 0);

    // R2 select mapping and readback
    wr(A_CTRL, 32'h0004_0000);
    chk("R2 cs from bit 18", {28'd0, cs}, 32'h4);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0004_0000);
    wr(A_CTRL, 0);
    chk("R2 all selects off", {28'd0, cs}, 0);

    // R4 all four modes, R3 small dividers including zero
    xfer(0, 0, 5'd0, 0, 8'hA5, 8'h3C, 0);
    xfer(0, 1, 5'd1, 1, 8'h96, 8'hE1, 0);
    xfer(1, 0, 5'd2, 2, 8'h01, 8'h80, 0);
    xfer(1, 1, 5'd3, 3, 8'hFE, 8'h7F, 0);
    xfer(0, 0, 5'd31, 1, 8'h5A, 8'hC3, 0);

    // random exchanges
    for (int k = 0; k < 20; k++) begin
      logic [4:0] p;
      p = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 6);
      xfer(1'($urandom), 1'($urandom), p, int'($urandom % 4),
           8'($urandom), 8'($urandom), 0);
    end

    // R5 done clears when the next exchange starts
    wr(A_CFG, cfg_word(0, 0, 5'd12));
    arm(0, 0, 5'd12, 8'h11);
    wr(A_TXD, 32'h22);
    rd(A_CTRL, v); chk("R5 done cleared by start", {31'd0, v[0]}, 0);
    wait_done(); s_en = 1'b0;

    // R6 write during busy ignored
    xfer(0, 1, 5'd9, 2, 8'hC3, 8'h5A, 1);

    // R7/R8 status and mask
    wr(A_MASK, 32'h1);
    chk("R8 irq with mask", {31'd0, irq}, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R7 zero write keeps", {31'd0, v[0]}, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R7 one write clears", v, 0);
    chk("R8 irq falls", {31'd0, irq}, 0);
    wr(A_MASK, 32'h0);
    xfer(1, 0, 5'd1, 0, 8'h3C, 8'h81, 0);
    chk("R8 irq masked off", {31'd0, irq}, 0);

    // R9 flush
    wr(A_MASK, 32'h2);
    wr(A_CFG, 32'h200 | cfg_word(1, 0, 5'd1));
    rd(A_CFG, v); chk("R9 flush self clears", v, cfg_word(1, 0, 5'd1));
    rd(A_RXD, v); chk("R9 rxd cleared", v, 0);
    rd(A_STAT, v); chk("R9 ready status", v, 32'h3);
    chk("R8 irq from ready", {31'd0, irq}, 1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R7 ready cleared alone", v, 32'h1);

    // R10 soft reset mid-exchange
    wr(A_CFG, cfg_word(1, 0, 5'd10));
    wr(A_CTRL, 32'h0002_0000);
    arm(1, 0, 5'd10, 8'hAA);
    wr(A_TXD, 32'h55);
    repeat (30) @(negedge clk);
    s_en = 1'b0;
    wr(A_CFG, 32'h1_0000 | cfg_word(1, 0, 5'd10));
    repeat (2) @(negedge clk);
    chk("R10 sclk idle after abort", {31'd0, sclk}, 1);
    rd(A_CTRL, v); chk("R10 cs kept done clear", v, 32'h0002_0000);
    rd(A_STAT, v); chk("R10 status cleared", v, 0);
    rd(A_CFG, v);  chk("R10 srst reads zero", v, cfg_word(1, 0, 5'd10));
    repeat (40) @(negedge clk);
    chk("R10 no edges after abort", {31'd0, sclk}, 1);
    xfer(1, 0, 5'd2, 1, 8'h0F, 8'hF0, 0);

    // R11 unimplemented bits
    wr(A_CFG, 32'h0002_3C20 | cfg_word(0, 1, 5'd2));
    rd(A_CFG, v); chk("R11 unused bits read zero", v, cfg_word(0, 1, 5'd2));
    xfer(0, 1, 5'd2, 3, 8'h69, 8'h96, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  localparam int A_LIST [1] = '{0};

endmodule